// File: doc/BRIEF.md
# Four-Function Integer ALU

This block is a purely combinational arithmetic and logic unit for two operands of the same width. A two-bit operation code picks one of four results: bitwise AND, bitwise OR, two's-complement addition or two's-complement subtraction. The selected value leaves on the result output through a final multiplexer.

Both arithmetic operations run on a single ripple-carry adder made of one-bit full adders. For subtraction, an XOR stage inverts every bit of the second operand and the adder's carry-in is forced high, so the adder computes A + ~B + 1. The carry out of the top bit is reported as the carry flag. The signed overflow flag is the XOR of the carry into the top bit and the carry out of it. The block has no clock and no state, so its outputs follow the inputs after the settling time of the carry chain.

The width is a parameter (default 32, minimum 2). The unit is placed in a datapath wherever a single-cycle add, subtract, AND or OR is needed together with carry and overflow information.

Top module: `alu4_core`

## Requirements
- R1: Operation code 2'b00 gives res_o = a_i & b_i, with carry_o = 0 and ovf_o = 0.
- R2: Operation code 2'b01 gives res_o = a_i | b_i, with carry_o = 0 and ovf_o = 0.
- R3: Operation code 2'b10 gives res_o = (a_i + b_i) mod 2^WIDTH, and carry_o is the carry out of bit WIDTH-1.
- R4: Operation code 2'b11 gives res_o = (a_i - b_i) mod 2^WIDTH, and carry_o is the carry out of a_i + ~b_i + 1. It is therefore 1 exactly when a_i >= b_i as unsigned numbers.
- R5: For operation codes 2'b10 and 2'b11, ovf_o equals the carry into bit WIDTH-1 XOR the carry out of bit WIDTH-1. This is the same as saying the signed result, read as two's complement, lies outside the range of WIDTH-bit numbers.
- R6: When both adder operands are non-negative (the second one taken after the subtract inversion) and the sum has its top bit set, ovf_o is 1. Examples: 2-bit 1 + 1 gives res 2'b10; 32-bit 0x7FFFFFFF + 1.
- R7: When both adder operands are negative and the sum has its top bit clear, ovf_o is 1. Examples: 2-bit -2 + -2 gives res 2'b00; 2-bit -1 + -2 gives res 2'b01.
- R8: When the carries into and out of the top bit agree, ovf_o is 0. This includes every case where the two adder operands have opposite signs. Examples: 2-bit -1 + -1 and 1 + -2.
- R9: The block holds no state. With all inputs at zero, every output is zero. Outputs depend only on the present inputs, at any WIDTH of 2 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Operation code: 00 AND, 01 OR, 10 ADD, 11 SUB |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| res_o | output | WIDTH | Selected result |
| carry_o | output | 1 | Carry out of the top adder bit; zero for logic operations |
| ovf_o | output | 1 | Signed overflow of add or subtract; zero for logic operations |

## Verification
The hardest situation to reach is the split between the two overflow causes, where the carry into the top bit and the carry out of it disagree in either direction. With wide random operands these cases are rare near the boundary values, and almost never come up under subtraction of extreme negatives. The bench therefore sweeps every operand pair and every operation at widths 2 and 4, so each combination of carry-in and carry-out at the top bit occurs many times. It then adds named 2-bit and 32-bit boundary vectors (most positive plus one, most negative plus itself, most negative minus one) and random 32-bit vectors for all four codes.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_ADD = 2'b10,
    OP_SUB = 2'b11
  } alu_op_e;

  // sum bit of a one-bit full adder
  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  // carry out of a one-bit full adder (majority of the three inputs)
  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  // signed overflow from the two carries around the top bit
  function automatic logic ovf_from_carries(input logic c_into_top, input logic c_out_top);
    return c_into_top ^ c_out_top;
  endfunction

endpackage

// File: rtl/alu4_full_adder.sv
module alu4_full_adder
  import alu4_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  always_comb begin
    s_o = fa_sum(x_i, y_i, c_i);
    c_o = fa_carry(x_i, y_i, c_i);
  end

endmodule

// File: rtl/alu4_cond_inv.sv
module alu4_cond_inv #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] b_o
);

  // one XOR per bit acts as a controlled inverter
  for (genvar k = 0; k < WIDTH; k++) begin : g_xor
    assign b_o[k] = b_i[k] ^ inv_i;
  end

endmodule

// File: rtl/alu4_logic_unit.sv
module alu4_logic_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sel_or_i,
  output logic [WIDTH-1:0] y_o
);

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    logic and_bit;
    logic or_bit;
    assign and_bit = a_i[k] & b_i[k];
    assign or_bit  = a_i[k] | b_i[k];
    assign y_o[k]  = sel_or_i ? or_bit : and_bit;
  end

endmodule

// File: rtl/alu4_ripple.sv
module alu4_ripple
  import alu4_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  // carry[k] enters bit k; carry[WIDTH] leaves the top bit
  logic [WIDTH:0] carry;
  logic           c_into_top;
  logic           c_out_top;

  assign carry[0] = cin_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    alu4_full_adder u_fa (
      .x_i (a_i[k]),
      .y_i (b_i[k]),
      .c_i (carry[k]),
      .s_o (sum_o[k]),
      .c_o (carry[k+1])
    );
  end

  assign c_into_top = carry[MSB];
  assign c_out_top  = carry[WIDTH];
  assign cout_o     = c_out_top;
  assign ovf_o      = ovf_from_carries(c_into_top, c_out_top);

  // chain arithmetic and overflow checked against the sign rule
  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      assert_chain_sum_R3: assert ({cout_o, sum_o} ==
          ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
        else $error("ripple chain sum mismatch");
      assert_sign_rule_R5: assert (ovf_o ==
          ((a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB])))
        else $error("overflow disagrees with operand sign rule");
      if (a_i[MSB] != b_i[MSB]) begin
        assert_mixed_sign_R8: assert (!ovf_o)
          else $error("overflow raised for operands of opposite sign");
      end
    end
  end

endmodule

// File: rtl/alu4_core.sv
module alu4_core
  import alu4_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             ovf_o
);

  // low opcode bit doubles as subtract control and OR select
  logic             sub_ctl;
  logic             is_arith;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic             add_cout;
  logic             add_ovf;
  logic [WIDTH-1:0] logic_y;

  assign sub_ctl  = op_i[0];
  assign is_arith = op_i[1];

  alu4_cond_inv #(.WIDTH(WIDTH)) u_inv (
    .b_i   (b_i),
    .inv_i (sub_ctl),
    .b_o   (b_eff)
  );

  alu4_ripple #(.WIDTH(WIDTH)) u_add (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (sub_ctl),
    .sum_o  (sum),
    .cout_o (add_cout),
    .ovf_o  (add_ovf)
  );

  alu4_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i      (a_i),
    .b_i      (b_i),
    .sel_or_i (sub_ctl),
    .y_o      (logic_y)
  );

  // output multiplexer
  always_comb begin
    if (is_arith) begin
      res_o   = sum;
      carry_o = add_cout;
      ovf_o   = add_ovf;
    end else begin
      res_o   = logic_y;
      carry_o = 1'b0;
      ovf_o   = 1'b0;
    end
  end

  // end-to-end relations between operands and selected outputs
  always_comb begin
    if (!$isunknown({op_i, a_i, b_i})) begin
      unique case (alu_op_e'(op_i))
        OP_AND: begin
          assert_and_result_R1: assert (res_o == (a_i & b_i) && !carry_o && !ovf_o)
            else $error("AND result or flags wrong");
        end
        OP_OR: begin
          assert_or_result_R2: assert (res_o == (a_i | b_i) && !carry_o && !ovf_o)
            else $error("OR result or flags wrong");
        end
        OP_ADD: begin
          assert_add_result_R3: assert (res_o == WIDTH'(a_i + b_i))
            else $error("ADD result wrong");
        end
        OP_SUB: begin
          assert_sub_result_R4: assert (res_o == WIDTH'(a_i - b_i) && carry_o == (a_i >= b_i))
            else $error("SUB result or borrow wrong");
        end
        default: ;
      endcase
    end
  end

endmodule

// File: tb/alu4_core_tb_top.sv
module alu4_core_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [1:0]  op = 2'b00;
  logic [31:0] a32 = '0, b32 = '0, r32;
  logic        c32, v32;
  logic [3:0]  a4 = '0, b4 = '0, r4;
  logic        c4, v4;
  logic [1:0]  a2 = '0, b2 = '0, r2;
  logic        c2, v2;

  alu4_core #(.WIDTH(32)) dut_i (
    .op_i(op), .a_i(a32), .b_i(b32), .res_o(r32), .carry_o(c32), .ovf_o(v32));
  alu4_core #(.WIDTH(4)) dut_w4 (
    .op_i(op), .a_i(a4), .b_i(b4), .res_o(r4), .carry_o(c4), .ovf_o(v4));
  alu4_core #(.WIDTH(2)) dut_w2 (
    .op_i(op), .a_i(a2), .b_i(b2), .res_o(r2), .carry_o(c2), .ovf_o(v2));

  task automatic check(input string tag, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // reference model written from the requirements with plain integers
  task automatic model(input int w, input logic [1:0] o, input longint ua, input longint ub,
                       output longint er, output longint ec, output longint ev);
    longint m, s, sa, sb, sr;
    m  = longint'(1) << w;
    sa = (ua >= m / 2) ? ua - m : ua;
    sb = (ub >= m / 2) ? ub - m : ub;
    er = 0; ec = 0; ev = 0;
    case (o)
      2'b00: er = ua & ub;
      2'b01: er = ua | ub;
      2'b10: begin
        s = ua + ub; er = s % m; ec = (s >= m) ? 1 : 0;
        sr = sa + sb; ev = (sr < -(m / 2) || sr >= m / 2) ? 1 : 0;
      end
      default: begin
        s = ua + (m - 1 - ub) + 1; er = s % m; ec = (s >= m) ? 1 : 0;
        sr = sa - sb; ev = (sr < -(m / 2) || sr >= m / 2) ? 1 : 0;
      end
    endcase
  endtask

  task automatic run_vec(input int w, input logic [1:0] o, input longint ua, input longint ub,
                         input string ovf_tag);
    longint er, ec, ev, gr, gc, gv;
    string  tag;
    @(posedge clk);
    op = o;
    if (w == 2)      begin a2 = ua[1:0];  b2 = ub[1:0];  end
    else if (w == 4) begin a4 = ua[3:0];  b4 = ub[3:0];  end
    else             begin a32 = ua[31:0]; b32 = ub[31:0]; end
    @(negedge clk);
    if (w == 2)      begin gr = longint'(r2);  gc = longint'(c2);  gv = longint'(v2);  end
    else if (w == 4) begin gr = longint'(r4);  gc = longint'(c4);  gv = longint'(v4);  end
    else             begin gr = longint'(r32); gc = longint'(c32); gv = longint'(v32); end
    model(w, o, ua, ub, er, ec, ev);
    case (o)
      2'b00: tag = "R1";
      2'b01: tag = "R2";
      2'b10: tag = "R3";
      default: tag = "R4";
    endcase
    check(tag, $sformatf("w%0d op%0d res", w, o), gr, er);
    check(tag, $sformatf("w%0d op%0d carry", w, o), gc, ec);
    check((o[1] ? ovf_tag : tag), $sformatf("w%0d op%0d ovf", w, o), gv, ev);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: no state, zero inputs give zero outputs
    check("R9", "idle res", longint'(r32), 0);
    check("R9", "idle flags", longint'({c32, v32}), 0);

    // named 2-bit corners
    run_vec(2, 2'b10, 2, 2, "R7");   // -2 + -2
    run_vec(2, 2'b10, 3, 2, "R7");   // -1 + -2
    run_vec(2, 2'b10, 1, 1, "R6");   //  1 +  1
    run_vec(2, 2'b10, 3, 3, "R8");   // -1 + -1
    run_vec(2, 2'b10, 1, 2, "R8");   //  1 + -2
    run_vec(2, 2'b11, 2, 1, "R7");   // -2 - 1

    // named 32-bit corners
    run_vec(32, 2'b10, 64'h7FFF_FFFF, 1, "R6");
    run_vec(32, 2'b10, 64'h8000_0000, 64'h8000_0000, "R7");
    run_vec(32, 2'b11, 0, 1, "R8");
    run_vec(32, 2'b11, 64'h8000_0000, 1, "R7");
    run_vec(32, 2'b11, 5, 5, "R8");
    run_vec(32, 2'b11, 64'h7FFF_FFFF, 64'hFFFF_FFFF, "R6");

    // exhaustive sweeps at widths 2 and 4 (R5 for overflow)
    for (int o = 0; o < 4; o++)
      for (int x = 0; x < 4; x++)
        for (int y = 0; y < 4; y++)
          run_vec(2, 2'(o), longint'(x), longint'(y), "R5");
    for (int o = 0; o < 4; o++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          run_vec(4, 2'(o), longint'(x), longint'(y), "R5");

    // random 32-bit vectors for every operation
    for (int o = 0; o < 4; o++)
      for (int n = 0; n < 200; n++)
        run_vec(32, 2'(o), longint'($urandom), longint'($urandom), "R5");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule